// File: doc/BRIEF.md
# Sticky Event Interrupt Controller

This block gathers single-cycle event pulses from a clock-synchronisation subsystem and holds each one in a sticky event register until software reads it. A separate read/write enable register selects which of the held events may pull down the one interrupt request line. The interrupt line is active low and comes from a register, so it has no combinational glitches.

Software samples the event register in the cycle it raises the read strobe. At the next clock edge every held bit is cleared, and the interrupt line is released unless a new enabled event arrives in that same cycle. An event that arrives together with the clearing read is kept, so no event is lost. Events are recorded whether or not they are enabled. The enable mask only decides whether the interrupt is raised.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After reset the event register and the enable register are 0 and `irq_n_o` is 1.
- R2: A pulse on `evt_pulse_i[i]` sets `evt_q_o[i]` to 1 at the next clock edge, and the bit stays 1 until a read clears it. Bit assignment: 7 lock lost, 6 signal lost, 5 active reference changed, 4 loop mode changed, 3 peer reference became active, 2 peer reference became idle, 1 some reference became usable, 0 some reference became unusable.
- R3: An event bit is recorded even while its enable bit is 0.
- R4: `evt_q_o` shows the held events in the cycle where `evt_rd_i` is high. At the next edge every bit is cleared, except bits whose pulse is present in that cycle.
- R5: A pulse that arrives in the same cycle as `evt_rd_i` leaves its bit set after the clearing edge.
- R6: When `ena_wr_i` is high, `ena_q_o` takes the value of `ena_wdata_i` at the next edge. Otherwise `ena_q_o` holds its value. A write never changes `evt_q_o`.
- R7: At every edge `irq_n_o` becomes 0 exactly when the new event value ANDed with the new enable value is nonzero. Otherwise it becomes 1. A change of the enable mask therefore shows on `irq_n_o` after one edge.
- R8: A read with no enabled event arriving in the same cycle returns `irq_n_o` to 1 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse_i | input | EVT_W | Single-cycle event pulses, one per bit |
| evt_rd_i | input | 1 | Event register read strobe; clears the register at the next edge |
| evt_q_o | output | EVT_W | Sticky event register |
| ena_wr_i | input | 1 | Enable register write strobe |
| ena_wdata_i | input | EVT_W | Enable register write data |
| ena_q_o | output | EVT_W | Enable register value |
| irq_n_o | output | 1 | Registered active-low interrupt request |

## Verification
The hardest case to reach is an event pulse that lands in exactly the cycle of the clearing read, especially when the enabled set of events changes in that same cycle. Stimulus that is left to chance seldom lines these up. The bench therefore builds this case directly: a pulse on one bit together with the read while another bit is held. The random phase then makes pulses, reads and enable writes overlap often enough to repeat the collision many times with different masks.

// File: rtl/evt_irq_pkg.sv
`timescale 1ns/1ps
package evt_irq_pkg;
   localparam int unsigned EVT_W_DEF = 8;

   // bit index of each event source inside the event register
   typedef enum int unsigned {
      EV_REF_UNUSABLE  = 0,
      EV_REF_USABLE    = 1,
      EV_PEER_IDLE     = 2,
      EV_PEER_ACTIVE   = 3,
      EV_LOOP_MODE_CHG = 4,
      EV_ACT_REF_CHG   = 5,
      EV_SIG_LOST      = 6,
      EV_LOCK_LOST     = 7
   } evt_idx_e;
endpackage

// File: rtl/evt_latch_cell.sv
`timescale 1ns/1ps
module evt_latch_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic pulse_i,
   input  logic clr_i,
   output logic d_o,
   output logic q_o
);
   // a pulse wins over the clear so a colliding event survives
   assign d_o = pulse_i | (q_o & ~clr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= 1'b0;
      else        q_o <= d_o;
   end
endmodule

// File: rtl/evt_ena_reg.sv
`timescale 1ns/1ps
module evt_ena_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] d_o,
   output logic [W-1:0] q_o
);
   assign d_o = wr_i ? wdata_i : q_o;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_o;
   end
endmodule

// File: rtl/evt_irq_gen.sv
`timescale 1ns/1ps
module evt_irq_gen #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt_d_i,
   input  logic [W-1:0] ena_d_i,
   output logic         irq_n_o
);
   logic req_d;

   assign req_d = |(evt_d_i & ena_d_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_n_o <= 1'b1;
      else        irq_n_o <= ~req_d;
   end
endmodule

// File: rtl/evt_irq_ctrl.sv
`timescale 1ns/1ps
module evt_irq_ctrl #(
   parameter int unsigned EVT_W = evt_irq_pkg::EVT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EVT_W-1:0] evt_pulse_i,
   input  logic             evt_rd_i,
   output logic [EVT_W-1:0] evt_q_o,
   input  logic             ena_wr_i,
   input  logic [EVT_W-1:0] ena_wdata_i,
   output logic [EVT_W-1:0] ena_q_o,
   output logic             irq_n_o
);
   generate
      if (EVT_W < 1 || EVT_W > 64) begin : g_bad_width
         $error("evt_irq_ctrl: EVT_W must lie in 1..64");
      end
   endgenerate

   logic [EVT_W-1:0] evt_d;
   logic [EVT_W-1:0] ena_d;

   generate
      for (genvar i = 0; i < EVT_W; i++) begin : g_cell
         evt_latch_cell u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .pulse_i (evt_pulse_i[i]),
            .clr_i   (evt_rd_i),
            .d_o     (evt_d[i]),
            .q_o     (evt_q_o[i])
         );
      end
   endgenerate

   evt_ena_reg #(.W(EVT_W)) u_ena (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ena_wr_i),
      .wdata_i (ena_wdata_i),
      .d_o     (ena_d),
      .q_o     (ena_q_o)
   );

   evt_irq_gen #(.W(EVT_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_d_i (evt_d),
      .ena_d_i (ena_d),
      .irq_n_o (irq_n_o)
   );
endmodule

// File: rtl/evt_irq_ctrl_chk.sv
`timescale 1ns/1ps
module evt_irq_ctrl_chk #(
   parameter int unsigned EVT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [EVT_W-1:0] evt_pulse_i,
   input logic             evt_rd_i,
   input logic [EVT_W-1:0] evt_q_o,
   input logic             ena_wr_i,
   input logic [EVT_W-1:0] ena_wdata_i,
   input logic [EVT_W-1:0] ena_q_o,
   input logic             irq_n_o
);
   assert_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (evt_q_o == '0 && ena_q_o == '0 && irq_n_o));

   assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_rd_i |=> ((evt_q_o & $past(evt_q_o)) == $past(evt_q_o)));

   // R3 and R5: every pulse is recorded, masked or not, read or not
   assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((evt_q_o & $past(evt_pulse_i)) == $past(evt_pulse_i)));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_rd_i |=> ((evt_q_o & ~$past(evt_pulse_i)) == '0));

   assert_ena_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ena_wr_i |=> (ena_q_o == $past(ena_wdata_i)));

   assert_ena_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !ena_wr_i |=> $stable(ena_q_o));

   assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (irq_n_o == ~|(evt_q_o & ena_q_o)));

   assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_rd_i && (evt_pulse_i == '0)) |=> irq_n_o);
endmodule

bind evt_irq_ctrl evt_irq_ctrl_chk #(.EVT_W(EVT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .evt_pulse_i (evt_pulse_i),
   .evt_rd_i    (evt_rd_i),
   .evt_q_o     (evt_q_o),
   .ena_wr_i    (ena_wr_i),
   .ena_wdata_i (ena_wdata_i),
   .ena_q_o     (ena_q_o),
   .irq_n_o     (irq_n_o)
);

// File: tb/evt_irq_ctrl_test.sv
`timescale 1ns/1ps
module evt_irq_ctrl_test;
   import evt_irq_pkg::*;

   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] evt_pulse_i = '0;
   logic         evt_rd_i = 1'b0;
   logic [W-1:0] evt_q_o;
   logic         ena_wr_i = 1'b0;
   logic [W-1:0] ena_wdata_i = '0;
   logic [W-1:0] ena_q_o;
   logic         irq_n_o;

   int n_chk = 0;
   int n_fail = 0;
   logic [W-1:0] evt_m = '0;
   logic [W-1:0] ena_m = '0;

   always #2.5 clk = ~clk;

   evt_irq_ctrl #(.EVT_W(W)) uut (.*);

   function automatic logic [W-1:0] next_evt(logic [W-1:0] cur, logic [W-1:0] p, logic rd);
      return (rd ? '0 : cur) | p;
   endfunction

   function automatic logic exp_irq_n(logic [W-1:0] e, logic [W-1:0] m);
      return ~|(e & m);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive at negedge, let one edge pass, compare at next negedge
   task automatic step(input logic [W-1:0] p, input logic rd, input logic wr,
                       input logic [W-1:0] wd, input string tag);
      evt_pulse_i = p; evt_rd_i = rd; ena_wr_i = wr; ena_wdata_i = wd;
      if (rd) check({tag, " R4 read data"}, 32'(evt_q_o), 32'(evt_m));
      @(posedge clk);
      evt_m = next_evt(evt_m, p, rd);
      if (wr) ena_m = wd;
      @(negedge clk);
      evt_pulse_i = '0; evt_rd_i = 1'b0; ena_wr_i = 1'b0;
      check({tag, " R2 events"}, 32'(evt_q_o), 32'(evt_m));
      check({tag, " R6 enable"}, 32'(ena_q_o), 32'(ena_m));
      check({tag, " R7 irq_n"}, 32'(irq_n_o), 32'(exp_irq_n(evt_m, ena_m)));
   endtask

   initial begin
      #(5ns * 150000);
      n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 events at reset", 32'(evt_q_o), 32'h0);
      check("R1 enable at reset", 32'(ena_q_o), 32'h0);
      check("R1 irq_n at reset", 32'(irq_n_o), 32'h1);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: masked event still recorded, no interrupt
      step(W'(1) << EV_LOCK_LOST, 1'b0, 1'b0, '0, "R3 masked lock lost");
      check("R3 irq stays high", 32'(irq_n_o), 32'h1);
      // R6: enabling raises irq, event bits untouched
      step('0, 1'b0, 1'b1, W'(1) << EV_LOCK_LOST, "R6 enable lock lost");
      check("R6 events unchanged", 32'(evt_q_o), 32'h80);
      check("R7 irq asserted", 32'(irq_n_o), 32'h0);
      // R8: read releases irq
      step('0, 1'b1, 1'b0, '0, "R8 read");
      check("R8 irq released", 32'(irq_n_o), 32'h1);
      check("R4 cleared", 32'(evt_q_o), 32'h0);
      // R5: collision of pulse and read
      step(W'(1) << EV_PEER_ACTIVE, 1'b0, 1'b0, '0, "R2 peer active");
      step(W'(1) << EV_SIG_LOST, 1'b1, 1'b0, '0, "R5 collide");
      check("R5 colliding bit kept", 32'(evt_q_o), 32'h40);
      // R7: pulse on enabled bit in the read cycle keeps irq low
      step('0, 1'b0, 1'b1, W'(1) << EV_SIG_LOST, "R7 enable sig lost");
      step(W'(1) << EV_SIG_LOST, 1'b1, 1'b0, '0, "R7 collide enabled");
      check("R7 irq held by colliding event", 32'(irq_n_o), 32'h0);
      step('0, 1'b1, 1'b1, '0, "R8 read with disable");
      check("R8 all clear", 32'(evt_q_o), 32'h0);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         logic [W-1:0] p;
         p = ($urandom % 4 == 0) ? W'(1) << ($urandom % W) : '0;
         if ($urandom % 16 == 0) p = W'($urandom);
         step(p, ($urandom % 8) == 0, ($urandom % 12) == 0, W'($urandom), "R2 random");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule